// File: doc/BRIEF.md
# On-Demand Single Conversion Sequencer

This block runs one-shot measurements for a sensor front end that spends most of its time powered down. A host sets a configuration word that selects the operating mode, the low-power submode that fixes how long a conversion lasts, a rate code, and which trigger source is live. A trigger comes either from an external pin, which passes through a synchronizer and a minimum-width filter, or from a software bit written through a register strobe. An accepted trigger opens a conversion window of fixed length. When the window ends, the block returns to power-down, emits a one-cycle sample strobe and raises a sticky data-ready flag.

Conversion lengths and the minimum start-to-start spacing are derived from a clock-frequency parameter given in kHz. The same RTL therefore runs at the real clock or at a scaled-down rate for fast simulation. Triggers that arrive while the block is busy, or too soon after the previous start, are discarded and are not queued.

Top module: `oneshot_conv_ctrl`

## Requirements
- R1: The configuration word is laid out as `{rate[3:0], mode[1:0], lpm[1:0], tsel}`, with rate in bits 8:5, mode in bits 4:3, lpm in bits 2:1 and tsel in bit 0. Conversions start only when mode is 10b. A mode of 00b, 01b or 11b makes every trigger have no effect.
- R2: With tsel = 0, the external pin starts a conversion once it has been seen high for at least MIN_HI_CYC consecutive synchronized cycles. A shorter high pulse is ignored, and each high phase yields at most one trigger. With tsel = 1 the pin is ignored.
- R3: With tsel = 1, a write strobe carrying data 1 starts a conversion and sets the software trigger bit. The bit stays set for the whole conversion and clears by itself in the cycle the conversion finishes. A write carrying 0, or any write while tsel = 0, has no effect.
- R4: conv_active stays high for exactly floor(T*CLK_KHZ) cycles, where T is 1.20, 1.70, 2.30 or 3.55 ms for lpm 00b, 01b, 10b or 11b. The submode is captured at the start of the conversion.
- R5: A rate field of 0000b holds the block in power-down, and every trigger from either source is ignored.
- R6: On completion, conv_active falls, sample_valid pulses high for exactly one cycle and drdy is set, all at the same clock edge.
- R7: drdy stays set until rd_ack is asserted. If completion and rd_ack fall in the same cycle, drdy is set.
- R8: A trigger that arrives during a conversion is ignored. It does not restart or extend the conversion and produces no extra sample_valid.
- R9: Two conversion starts are at least floor(5*CLK_KHZ) cycles apart. A trigger that arrives earlier is discarded and is not held over.
- R10: After reset, conv_active, sample_valid, drdy and sw_trig_bit are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 9 | Configuration: rate, mode, low-power submode, trigger select |
| trig_pin | input | 1 | External trigger pin, asynchronous |
| sw_wr | input | 1 | Write strobe for the software trigger bit |
| sw_wdata | input | 1 | Value written with sw_wr |
| rd_ack | input | 1 | Output stage has read the sample; clears drdy |
| conv_active | output | 1 | Front end powered and converting |
| sample_valid | output | 1 | One-cycle strobe at end of conversion |
| drdy | output | 1 | Sticky data-ready flag |
| sw_trig_bit | output | 1 | Self-clearing software trigger bit |

## Verification
The bench triggers conversions from the pin in each of the four submodes and measures the length of every window, which shows whether the duration table is indexed correctly. Pin pulses just below and just above the width threshold separate a working filter from a bare edge detector. Triggers are repeated during a running conversion, and again between its end and the spacing limit. These tell apart a design that restarts its timer, one that only blocks triggers while busy, and one that enforces the full start-to-start gap. Non-single modes, a zero rate code, writes carrying 0 and the unselected source are each driven to confirm that no conversion occurs.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef struct packed {
    logic [3:0] rate;
    logic [1:0] mode;
    logic [1:0] lpm;
    logic       tsel;
  } cfg_t;

  localparam logic [1:0] MODE_SINGLE = 2'b10;

  typedef enum logic {ST_OFF = 1'b0, ST_CONV = 1'b1} st_t;

  // conversion lengths in units of 10 us, indexed by submode
  localparam int unsigned T_LPM0 = 120;
  localparam int unsigned T_LPM1 = 170;
  localparam int unsigned T_LPM2 = 230;
  localparam int unsigned T_LPM3 = 355;
  localparam int unsigned T_GAP  = 500;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned MIN_HI_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic hit
);
  localparam int unsigned HW = $clog2(MIN_HI_CYC + 1);

  logic          s1_q, s2_q;
  logic [HW-1:0] hi_q, hi_d;

  always_comb begin
    hi_d = hi_q;
    if (!s2_q)
      hi_d = '0;
    else if (hi_q != HW'(MIN_HI_CYC))
      hi_d = hi_q + 1'b1;
  end

  assign hit = s2_q && (hi_q == HW'(MIN_HI_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      hi_q <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/oneshot_conv_ctrl.sv
module oneshot_conv_ctrl
  import oneshot_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 125000,
  parameter int unsigned MIN_HI_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [8:0] cfg_word,
  input  logic       trig_pin,
  input  logic       sw_wr,
  input  logic       sw_wdata,
  input  logic       rd_ack,
  output logic       conv_active,
  output logic       sample_valid,
  output logic       drdy,
  output logic       sw_trig_bit
);
  localparam int unsigned DUR0    = T_LPM0 * CLK_KHZ / 100;
  localparam int unsigned DUR1    = T_LPM1 * CLK_KHZ / 100;
  localparam int unsigned DUR2    = T_LPM2 * CLK_KHZ / 100;
  localparam int unsigned DUR3    = T_LPM3 * CLK_KHZ / 100;
  localparam int unsigned GAP_CYC = T_GAP  * CLK_KHZ / 100;
  localparam int unsigned CNT_W   = $clog2(GAP_CYC + 1);

  cfg_t             cfg;
  st_t              st_q, st_d;
  logic             ext_hit, sw_hit, trig, armed, start;
  logic             dur_exp, gap_exp, conv_done;
  logic [CNT_W-1:0] dur_val;
  logic             sv_q, drdy_q, drdy_d, swb_q, swb_d;

  assign cfg = cfg_word;

  trig_sync #(.MIN_HI_CYC(MIN_HI_CYC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (trig_pin),
    .hit   (ext_hit)
  );

  assign sw_hit = sw_wr && sw_wdata;
  assign trig   = cfg.tsel ? sw_hit : ext_hit;
  assign armed  = (cfg.mode == MODE_SINGLE) && (cfg.rate != 4'd0);
  assign start  = armed && trig && (st_q == ST_OFF) && gap_exp;

  always_comb begin
    case (cfg.lpm)
      2'b00:   dur_val = CNT_W'(DUR0 - 1);
      2'b01:   dur_val = CNT_W'(DUR1 - 1);
      2'b10:   dur_val = CNT_W'(DUR2 - 1);
      default: dur_val = CNT_W'(DUR3 - 1);
    endcase
  end

  conv_timer #(.W(CNT_W)) u_dur (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (dur_val),
    .expired  (dur_exp)
  );

  conv_timer #(.W(CNT_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (CNT_W'(GAP_CYC - 1)),
    .expired  (gap_exp)
  );

  assign conv_done = (st_q == ST_CONV) && dur_exp;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OFF:  if (start)     st_d = ST_CONV;
      ST_CONV: if (conv_done) st_d = ST_OFF;
      default:                st_d = ST_OFF;
    endcase
  end

  always_comb begin
    drdy_d = drdy_q;
    if (conv_done)   drdy_d = 1'b1;
    else if (rd_ack) drdy_d = 1'b0;
    swb_d = swb_q;
    if (start && cfg.tsel) swb_d = 1'b1;
    else if (conv_done)    swb_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      sv_q   <= 1'b0;
      drdy_q <= 1'b0;
      swb_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sv_q   <= conv_done;
      drdy_q <= drdy_d;
      swb_q  <= swb_d;
    end
  end

  assign conv_active  = (st_q == ST_CONV);
  assign sample_valid = sv_q;
  assign drdy         = drdy_q;
  assign sw_trig_bit  = swb_q;
endmodule

// File: rtl/oneshot_conv_chk.sv
module oneshot_conv_chk #(
  parameter int unsigned GAP_CYC = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] cfg_word,
  input logic       conv_active,
  input logic       sample_valid,
  input logic       drdy,
  input logic       sw_trig_bit
);
  localparam int unsigned SW = $clog2(GAP_CYC + 1);

  logic          prev_act_q;
  logic [SW-1:0] since_q;
  logic          rise;

  assign rise = conv_active && !prev_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act_q <= 1'b0;
      since_q    <= SW'(GAP_CYC);
    end else begin
      prev_act_q <= conv_active;
      if (rise)
        since_q <= SW'(1);
      else if (since_q != SW'(GAP_CYC))
        since_q <= since_q + 1'b1;
    end
  end

  AST_START_ONLY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_active) |-> ($past(cfg_word[4:3]) == 2'b10) && ($past(cfg_word[8:5]) != 4'd0)); // R1
  AST_SWBIT_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig_bit |-> conv_active); // R3
  AST_SV_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(conv_active) && !conv_active); // R6
  AST_SV_SETS_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> drdy); // R6
  AST_SV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R6
  AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (since_q == SW'(GAP_CYC))); // R9
endmodule

bind oneshot_conv_ctrl oneshot_conv_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_word     (cfg_word),
  .conv_active  (conv_active),
  .sample_valid (sample_valid),
  .drdy         (drdy),
  .sw_trig_bit  (sw_trig_bit)
);

// File: tb/oneshot_conv_ctrl_test.sv
`timescale 1ns/1ps
module oneshot_conv_ctrl_test;
  localparam int unsigned CLK_KHZ = 10;
  localparam int unsigned MIN_HI  = 3;

  logic       clk, rst_n;
  logic [8:0] cfg_word;
  logic       trig_pin, sw_wr, sw_wdata, rd_ack;
  logic       conv_active, sample_valid, drdy, sw_trig_bit;

  int checks, errors, act_cyc, sv_cnt;
  bit done;

  oneshot_conv_ctrl #(.CLK_KHZ(CLK_KHZ), .MIN_HI_CYC(MIN_HI)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .trig_pin(trig_pin),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .rd_ack(rd_ack),
    .conv_active(conv_active), .sample_valid(sample_valid),
    .drdy(drdy), .sw_trig_bit(sw_trig_bit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (conv_active)  act_cyc++;
    if (sample_valid) sv_cnt++;
  end

  function automatic logic [8:0] mk(input logic [3:0] rate, input logic [1:0] mode,
                                    input logic [1:0] lpm, input logic tsel);
    return {rate, mode, lpm, tsel};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    act_cyc = 0;
    sv_cnt  = 0;
  endtask

  task automatic pulse_pin(input int n);
    @(negedge clk) trig_pin = 1'b1;
    repeat (n) @(negedge clk);
    trig_pin = 1'b0;
  endtask

  task automatic sw_write(input logic v);
    @(negedge clk) begin sw_wr = 1'b1; sw_wdata = v; end
    @(negedge clk) sw_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (70) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!conv_active && !sample_valid && !drdy && !sw_trig_bit, "R10 reset outputs",
          {conv_active, sample_valid, drdy, sw_trig_bit}, 0);
  endtask

  task automatic t_durations();
    int exp_d[4] = '{12, 17, 23, 35};
    for (int l = 0; l < 4; l++) begin
      cfg_word = mk(4'd3, 2'b10, 2'(l), 1'b0);
      clr();
      pulse_pin(MIN_HI);
      settle();
      check(act_cyc == exp_d[l], "R4 duration per submode", act_cyc, exp_d[l]);
      check(sv_cnt == 1, "R6 one sample_valid", sv_cnt, 1);
      check(drdy == 1'b1, "R6 drdy set", drdy, 1);
      @(negedge clk) rd_ack = 1'b1;
      @(negedge clk) rd_ack = 1'b0;
      check(drdy == 1'b0, "R7 drdy cleared by rd_ack", drdy, 0);
    end
  endtask

  task automatic t_short_pulse();
    cfg_word = mk(4'd3, 2'b10, 2'b00, 1'b0);
    clr();
    pulse_pin(MIN_HI - 1);
    settle();
    check(act_cyc == 0, "R2 short pin pulse ignored", act_cyc, 0);
    clr();
    pulse_pin(MIN_HI);
    settle();
    check(act_cyc == 12, "R2 pin pulse at minimum width", act_cyc, 12);
  endtask

  task automatic t_rate_zero();
    cfg_word = mk(4'd0, 2'b10, 2'b00, 1'b0);
    clr();
    pulse_pin(MIN_HI + 2);
    settle();
    check(act_cyc == 0 && sv_cnt == 0, "R5 rate zero pin ignored", act_cyc, 0);
    cfg_word = mk(4'd0, 2'b10, 2'b00, 1'b1);
    clr();
    sw_write(1'b1);
    check(sw_trig_bit == 1'b0, "R5 rate zero sw bit stays low", sw_trig_bit, 0);
    settle();
    check(act_cyc == 0, "R5 rate zero sw ignored", act_cyc, 0);
  endtask

  task automatic t_modes();
    logic [1:0] md[3] = '{2'b00, 2'b01, 2'b11};
    for (int i = 0; i < 3; i++) begin
      cfg_word = mk(4'd3, md[i], 2'b00, 1'b0);
      clr();
      pulse_pin(MIN_HI + 2);
      settle();
      check(act_cyc == 0 && sv_cnt == 0, "R1 non-single mode ignores trigger", act_cyc, 0);
    end
  endtask

  task automatic t_sw();
    cfg_word = mk(4'd3, 2'b10, 2'b01, 1'b1);
    clr();
    sw_write(1'b1);
    check(sw_trig_bit == 1'b1, "R3 sw bit set at start", sw_trig_bit, 1);
    check(conv_active == 1'b1, "R3 sw write starts conversion", conv_active, 1);
    settle();
    check(act_cyc == 17, "R3 sw conversion length", act_cyc, 17);
    check(sw_trig_bit == 1'b0, "R3 sw bit self-clears", sw_trig_bit, 0);
    clr();
    sw_write(1'b0);
    settle();
    check(act_cyc == 0, "R3 write of zero no effect", act_cyc, 0);
    clr();
    pulse_pin(MIN_HI + 2);
    settle();
    check(act_cyc == 0, "R2 pin ignored when tsel=1", act_cyc, 0);
    cfg_word = mk(4'd3, 2'b10, 2'b01, 1'b0);
    clr();
    sw_write(1'b1);
    check(sw_trig_bit == 1'b0, "R3 sw write ignored when tsel=0", sw_trig_bit, 0);
    settle();
    check(act_cyc == 0, "R3 sw write with tsel=0 no conversion", act_cyc, 0);
  endtask

  task automatic t_retrigger();
    cfg_word = mk(4'd3, 2'b10, 2'b00, 1'b0);
    clr();
    pulse_pin(MIN_HI + 1);
    repeat (2) @(negedge clk);
    pulse_pin(MIN_HI + 1);
    settle();
    check(act_cyc == 12, "R8 retrigger does not extend", act_cyc, 12);
    check(sv_cnt == 1, "R8 retrigger no extra sample", sv_cnt, 1);
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
  endtask

  task automatic t_gap();
    cfg_word = mk(4'd3, 2'b10, 2'b00, 1'b1);
    clr();
    sw_write(1'b1);
    repeat (20) @(negedge clk);
    check(conv_active == 1'b0, "R9 first conversion over", conv_active, 0);
    sw_write(1'b1);
    check(sw_trig_bit == 1'b0 && conv_active == 1'b0, "R9 early trigger discarded",
          conv_active, 0);
    repeat (30) @(negedge clk);
    check(act_cyc == 12 && sv_cnt == 1, "R9 only one conversion inside gap", act_cyc, 12);
    sw_write(1'b1);
    settle();
    check(act_cyc == 24 && sv_cnt == 2, "R9 trigger after gap accepted", act_cyc, 24);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    clr();
    rst_n = 1'b0; cfg_word = '0; trig_pin = 1'b0;
    sw_wr = 1'b0; sw_wdata = 1'b0; rd_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_durations();
    t_short_pulse();
    t_rate_zero();
    t_modes();
    t_sw();
    t_retrigger();
    t_gap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule